// File: doc/BRIEF.md
# Radix-2 Butterfly with Deferred Twiddle Multiply

This block is the arithmetic core of a memory-based radix-2 decimation-in-frequency FFT engine. Each accepted operation takes two complex samples and forms their half-scaled sum and half-scaled difference. The sum needs no twiddle factor, so it leaves the block on the next clock edge together with its write-enable, ready to be written back to the data memory. The difference is not always multiplied at once. In deferred mode it goes into a small scratch bank at a slot chosen by the caller. In the same cycle, the value that slot held before is read out and sent through the complex multiplier with the twiddle now on the twiddle inputs. The multiply for one group of butterflies therefore overlaps the additions of another, and the multiplier can do useful work on every cycle.

In direct mode, which is used for the first FFT stage, the difference goes straight into the multiplier and the scratch bank is left alone. A drain operation reads and multiplies a stored difference without starting a new butterfly, and it marks that slot empty. Address generation and the main data memories belong to the surrounding engine. The complex multiply and the saturating rounding fit in the same cycle as the add and subtract, so every result is registered exactly once.

Top module: `bfly_deferred`

## Requirements
- R1: During and directly after reset, sum_we and prod_we are 0 and every data output is 0. Every scratch slot starts empty, so a drain of any slot gives prod_we=0.
- R2: When in_valid=1 and drain=0, the next cycle shows sum_we=1. sum_re is floor((a_re+b_re)/2) and sum_im is floor((a_im+b_im)/2), and these values cannot overflow.
- R3: When in_valid=0, the next cycle shows sum_we=0 and prod_we=0, and all four data outputs keep their previous values.
- R4: When in_valid=1, drain=0 and mode_direct=1, the next cycle shows prod_we=1 with prod = sat(floor(d*w / 2^15)). Here d is the complex value floor((a-b)/2), and w is tw_re + j*tw_im in Q1.15. The real part is d_re*w_re - d_im*w_im and the imaginary part is d_re*w_im + d_im*w_re.
- R5: When in_valid=1, drain=0 and mode_direct=0, the new difference is stored in slot `slot` and the slot is marked occupied. The product of the value the slot held before and the current twiddle appears on the next cycle with prod_we=1, but only if the slot was occupied. An empty slot gives prod_we=0, and the prod outputs keep their values.
- R6: When in_valid=1 and drain=1, in either mode, no sum is produced: sum_we=0 and the sum outputs hold. The slot is read and multiplied as in R5, and it becomes empty.
- R7: Each product component is clamped to the range -32768 to 32767 when the scaled result falls outside it.
- R8: Direct-mode operations neither read nor change the scratch bank. Differences stored earlier come out unchanged at a later drain.
- R9: Operations may be issued back to back on every cycle at one slot. Each one returns the difference written by the previous operation at that slot, never the one being written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is issued this cycle |
| mode_direct | input | 1 | 1: multiply the difference at once; 0: store it in the scratch bank |
| drain | input | 1 | Multiply a stored difference only, with no new butterfly |
| slot | input | SCR_AW | Scratch bank slot, read then written in the same cycle |
| a_re | input | 16 | Operand A, real part |
| a_im | input | 16 | Operand A, imaginary part |
| b_re | input | 16 | Operand B, real part |
| b_im | input | 16 | Operand B, imaginary part |
| tw_re | input | 16 | Twiddle real part, Q1.15 |
| tw_im | input | 16 | Twiddle imaginary part, Q1.15 |
| sum_we | output | 1 | Sum write-enable |
| sum_re | output | 16 | Half-scaled sum, real part |
| sum_im | output | 16 | Half-scaled sum, imaginary part |
| prod_we | output | 1 | Product write-enable |
| prod_re | output | 16 | Twiddled product, real part |
| prod_im | output | 16 | Twiddled product, imaginary part |

## Verification
The assertions assume that in_valid, drain and mode_direct are known, 0 or 1, at every sampling edge after reset, and that in_valid stays 0 while reset is applied. They say nothing about which values appear on the operand or twiddle inputs. The bench changes every input only on the falling clock edge and holds in_valid low through reset. It draws operands and twiddles from the full signed range, including the extreme values that force saturation. It also leaves idle cycles between bursts, so the hold properties are exercised as well as the enable properties.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Sample width and fraction width of the Q1.15 format
    localparam int unsigned CW     = 16;
    localparam int unsigned FRAC_W = CW - 1;
    // Width of a complex-multiply accumulator: two full products plus a carry
    localparam int unsigned PW     = 2 * CW + 1;

    typedef logic signed [CW-1:0] samp_t;

    typedef struct packed {
        samp_t re;
        samp_t im;
    } cplx_t;

endpackage

// File: rtl/bfly_addsub.sv
module bfly_addsub
    import bfly_pkg::*;
(
    input  cplx_t op_a,
    input  cplx_t op_b,
    output cplx_t half_sum,
    output cplx_t half_dif
);

    // One guard bit, then an arithmetic shift right by one (floor of x/2)
    function automatic samp_t halve(input logic signed [CW:0] v);
        logic signed [CW:0] sh;
        sh = v >>> 1;
        return samp_t'(sh);
    endfunction

    logic signed [CW:0] s_re, s_im, d_re, d_im;

    always_comb begin
        s_re = {op_a.re[CW-1], op_a.re} + {op_b.re[CW-1], op_b.re};
        s_im = {op_a.im[CW-1], op_a.im} + {op_b.im[CW-1], op_b.im};
        d_re = {op_a.re[CW-1], op_a.re} - {op_b.re[CW-1], op_b.re};
        d_im = {op_a.im[CW-1], op_a.im} - {op_b.im[CW-1], op_b.im};
        half_sum.re = halve(s_re);
        half_sum.im = halve(s_im);
        half_dif.re = halve(d_re);
        half_dif.im = halve(d_im);
    end

endmodule

// File: rtl/bfly_cmul.sv
module bfly_cmul
    import bfly_pkg::*;
(
    input  cplx_t x,
    input  cplx_t w,
    output cplx_t y
);

    localparam samp_t SAT_HI = samp_t'((2 ** (CW - 1)) - 1);
    localparam samp_t SAT_LO = samp_t'(-(2 ** (CW - 1)));

    // Scale a Q2.30 accumulator to Q1.15 and clamp it
    function automatic samp_t scale_sat(input logic signed [PW-1:0] acc);
        logic signed [PW-1:0] sh;
        logic                 ovf;
        sh  = acc >>> FRAC_W;
        ovf = !((&sh[PW-1:CW-1]) || !(|sh[PW-1:CW-1]));
        if (ovf) begin
            return sh[PW-1] ? SAT_LO : SAT_HI;
        end
        return samp_t'(sh[CW-1:0]);
    endfunction

    logic signed [2*CW-1:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [PW-1:0]   acc_re, acc_im;

    always_comb begin
        p_rr   = x.re * w.re;
        p_ii   = x.im * w.im;
        p_ri   = x.re * w.im;
        p_ir   = x.im * w.re;
        acc_re = PW'(p_rr) - PW'(p_ii);
        acc_im = PW'(p_ri) + PW'(p_ir);
        y.re   = scale_sat(acc_re);
        y.im   = scale_sat(acc_im);
    end

endmodule

// File: rtl/bfly_scratch.sv
module bfly_scratch
    import bfly_pkg::*;
#(
    parameter  int unsigned DEPTH = 16,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          clr_en,
    input  cplx_t         wr_data,
    output cplx_t         rd_data,
    output logic          rd_full
);

    typedef struct packed {
        cplx_t [DEPTH-1:0] mem;
        logic  [DEPTH-1:0] full;
    } scr_state_t;

    scr_state_t st_d, st_q;

    // Read phase sees the registered contents; write lands at the clock edge
    assign rd_data = st_q.mem[addr];
    assign rd_full = st_q.full[addr];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[addr]  = wr_data;
            st_d.full[addr] = 1'b1;
        end else if (clr_en) begin
            st_d.full[addr] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bfly_deferred.sv
module bfly_deferred
    import bfly_pkg::*;
#(
    parameter  int unsigned SCR_DEPTH = 16,
    localparam int unsigned SCR_AW    = (SCR_DEPTH > 1) ? $clog2(SCR_DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                mode_direct,
    input  logic                drain,
    input  logic [SCR_AW-1:0]   slot,
    input  logic signed [15:0]  a_re,
    input  logic signed [15:0]  a_im,
    input  logic signed [15:0]  b_re,
    input  logic signed [15:0]  b_im,
    input  logic signed [15:0]  tw_re,
    input  logic signed [15:0]  tw_im,
    output logic                sum_we,
    output logic signed [15:0]  sum_re,
    output logic signed [15:0]  sum_im,
    output logic                prod_we,
    output logic signed [15:0]  prod_re,
    output logic signed [15:0]  prod_im
);

    typedef struct packed {
        logic  sum_we;
        cplx_t sum;
        logic  prod_we;
        cplx_t prod;
    } out_state_t;

    out_state_t st_d, st_q;

    cplx_t op_a, op_b, tw;
    cplx_t half_sum, half_dif;
    cplx_t scr_rd, mul_src, mul_res;
    logic  scr_full;
    logic  do_butterfly, do_store, do_clear, do_mul;

    assign op_a = '{re: a_re,  im: a_im};
    assign op_b = '{re: b_re,  im: b_im};
    assign tw   = '{re: tw_re, im: tw_im};

    bfly_addsub u_addsub (
        .op_a     (op_a),
        .op_b     (op_b),
        .half_sum (half_sum),
        .half_dif (half_dif)
    );

    // Operation decode
    always_comb begin
        do_butterfly = in_valid && !drain;
        do_store     = do_butterfly && !mode_direct;
        do_clear     = in_valid && drain;
        if (do_butterfly && mode_direct) begin
            mul_src = half_dif;
            do_mul  = 1'b1;
        end else begin
            mul_src = scr_rd;
            do_mul  = in_valid && scr_full;
        end
    end

    bfly_scratch #(
        .DEPTH (SCR_DEPTH)
    ) u_scratch (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (slot),
        .wr_en   (do_store),
        .clr_en  (do_clear),
        .wr_data (half_dif),
        .rd_data (scr_rd),
        .rd_full (scr_full)
    );

    bfly_cmul u_cmul (
        .x (mul_src),
        .w (tw),
        .y (mul_res)
    );

    always_comb begin
        st_d         = st_q;
        st_d.sum_we  = 1'b0;
        st_d.prod_we = 1'b0;
        if (do_butterfly) begin
            st_d.sum_we = 1'b1;
            st_d.sum    = half_sum;
        end
        if (do_mul) begin
            st_d.prod_we = 1'b1;
            st_d.prod    = mul_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_we  = st_q.sum_we;
    assign sum_re  = st_q.sum.re;
    assign sum_im  = st_q.sum.im;
    assign prod_we = st_q.prod_we;
    assign prod_re = st_q.prod.re;
    assign prod_im = st_q.prod.im;

endmodule

// File: rtl/bfly_deferred_chk.sv
module bfly_deferred_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               mode_direct,
    input logic               drain,
    input logic               sum_we,
    input logic signed [15:0] sum_re,
    input logic signed [15:0] sum_im,
    input logic               prod_we,
    input logic signed [15:0] prod_re,
    input logic signed [15:0] prod_im
);

    // R2: a butterfly operation always yields a sum write
    a_r2_sum_issued: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !drain) |=> sum_we);

    // R3: idle cycles produce no writes
    a_r3_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!sum_we && !prod_we));

    // R3: idle cycles leave the data outputs unchanged
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_re) && $stable(sum_im)
                       && $stable(prod_re) && $stable(prod_im)));

    // R4: a direct-mode butterfly always yields a product write
    a_r4_direct_prod: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !drain && mode_direct) |=> prod_we);

    // R6: a drain produces no sum and keeps the sum outputs
    a_r6_drain_no_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && drain) |=> (!sum_we && $stable(sum_re) && $stable(sum_im)));

endmodule

bind bfly_deferred bfly_deferred_chk u_chk (.*);

// File: tb/tb_bfly_deferred.sv
`timescale 1ns/1ps
module tb_bfly_deferred;

    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, mode_direct = 1'b0, drain = 1'b0;
    logic [AW-1:0] slot = '0;
    logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0, tw_re = '0, tw_im = '0;
    logic sum_we, prod_we;
    logic signed [15:0] sum_re, sum_im, prod_re, prod_im;

    always #2 clk = ~clk;

    bfly_deferred #(.SCR_DEPTH(DEPTH)) dut (.*);

    typedef struct {
        bit    swe;
        int    sr, si;
        bit    pwe;
        int    pr, pi;
        string stag;
        string ptag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0, n_bad = 0;
    bit   done = 1'b0;

    // Reference state
    int m_re[DEPTH], m_im[DEPTH];
    bit m_full[DEPTH];
    int last_sr = 0, last_si = 0, last_pr = 0, last_pi = 0;

    function automatic int half(input int x, input int y, input bit sub);
        int s;
        s = sub ? x - y : x + y;
        return s >>> 1;
    endfunction

    function automatic int sat16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int mre(input int dr, di, wr, wi);
        longint acc;
        acc = longint'(dr) * wr - longint'(di) * wi;
        return sat16(acc >>> 15);
    endfunction

    function automatic int mim(input int dr, di, wr, wi);
        longint acc;
        acc = longint'(dr) * wi + longint'(di) * wr;
        return sat16(acc >>> 15);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Driver: issue one cycle and record what it must produce
    task automatic op(input bit v, md, dr, input int s,
                      input int ar, ai, br, bi, wr, wi, input string ptag);
        exp_t e;
        int dre, dim;
        @(negedge clk);
        in_valid = v; mode_direct = md; drain = dr; slot = AW'(s);
        a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
        tw_re = 16'(wr); tw_im = 16'(wi);
        e.ptag = ptag;
        e.stag = !v ? "R3" : (dr ? "R6" : "R2");
        e.swe = v && !dr;
        if (e.swe) begin
            last_sr = half(ar, br, 1'b0);
            last_si = half(ai, bi, 1'b0);
        end
        dre = half(ar, br, 1'b1);
        dim = half(ai, bi, 1'b1);
        e.pwe = 1'b0;
        if (v && !dr && md) begin
            e.pwe = 1'b1;
            last_pr = mre(dre, dim, wr, wi);
            last_pi = mim(dre, dim, wr, wi);
        end else if (v) begin
            if (m_full[s]) begin
                e.pwe = 1'b1;
                last_pr = mre(m_re[s], m_im[s], wr, wi);
                last_pi = mim(m_re[s], m_im[s], wr, wi);
            end
            if (dr) begin
                m_full[s] = 1'b0;
            end else begin
                m_re[s] = dre; m_im[s] = dim; m_full[s] = 1'b1;
            end
        end
        e.sr = last_sr; e.si = last_si; e.pr = last_pr; e.pi = last_pi;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    endtask

    function automatic int rnd16();
        return int'($signed(16'($urandom)));
    endfunction

    // Monitor: compare one expected item per cycle, after the edge settles
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(e.stag, "sum_we", int'(sum_we), int'(e.swe));
                check(e.stag, "sum_re", int'(sum_re), e.sr);
                check(e.stag, "sum_im", int'(sum_im), e.si);
                check(e.ptag, "prod_we", int'(prod_we), int'(e.pwe));
                check(e.ptag, "prod_re", int'(prod_re), e.pr);
                check(e.ptag, "prod_im", int'(prod_im), e.pi);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_full[i] = 1'b0; m_re[i] = 0; m_im[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state at the ports
        check("R1", "sum_we", int'(sum_we), 0);
        check("R1", "prod_we", int'(prod_we), 0);
        check("R1", "sum_re", int'(sum_re), 0);
        check("R1", "prod_im", int'(prod_im), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every slot starts empty
        for (int s = 0; s < DEPTH; s++) op(1, 0, 1, s, 0, 0, 0, 0, 16384, 0, "R1");

        // R2/R4: direct mode with assorted patterns
        op(1, 1, 0, 0, 1000, -2000, 300, 400, 32767, 0, "R4");
        op(1, 1, 0, 0, -7, 5, 4, -3, 23170, -23170, "R4");
        op(1, 1, 0, 0, 32767, 32767, 32767, 32767, 0, 32767, "R4");
        for (int i = 0; i < 20; i++)
            op(1, 1, 0, 0, rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), "R4");

        // R7: saturation corners
        op(1, 1, 0, 0, -32768, -32768, 32767, 32767, -32768, -32768, "R7");
        op(1, 1, 0, 0, 32767, -32768, -32768, 32767, -32768, 32767, "R7");
        op(1, 1, 0, 0, -32768, 32767, 32767, -32768, -32768, -32768, "R7");

        // R3: idle cycles hold outputs
        idle(4);

        // R5: fill slots (empty, so no product), then refill and get old values
        for (int s = 0; s < 8; s++)
            op(1, 0, 0, s, rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), "R5");
        for (int s = 0; s < 8; s++)
            op(1, 0, 0, s, rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), "R5");

        // R9: same slot every cycle, back to back
        for (int i = 0; i < 10; i++)
            op(1, 0, 0, 3, rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), "R9");

        // R8: direct ops in between must not disturb stored differences
        for (int i = 0; i < 6; i++)
            op(1, 1, 0, i, rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), "R8");
        idle(2);
        for (int s = 0; s < 8; s++)
            op(1, s[0], 1, s, rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), "R8");

        // R6: drained slots are empty afterwards
        for (int s = 0; s < 8; s++)
            op(1, 0, 1, s, rnd16(), rnd16(), 0, 0, 16384, 16384, "R6");

        // Mixed traffic
        for (int i = 0; i < 200; i++)
            op($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 3) == 0,
               $urandom_range(0, DEPTH - 1), rnd16(), rnd16(), rnd16(), rnd16(),
               rnd16(), rnd16(), "R5");

        idle(3);
        while (exp_q.size() > 0) @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule